// File: doc/BRIEF.md
# Randomized Sampling Period Generator

This block arms an operation-sampling counter with a period that changes at random from one arm to the next. Sampled code that is itself periodic then does not line up with a fixed sampling interval. A 16-bit linear feedback shift register supplies the randomness. From the requested period, the block builds a 64-bit control word that carries the maximum count, a starting current count, an enable bit and a count-mode bit. It issues a new control word on start and on every valid sample while sampling runs, and issues an all-zero word on stop.

Two strategies cover the two kinds of counter hardware. When the counter's current-count field can be written, the low 12 bits of the random value seed that field. The maximum count is then raised by half the random range, so the mean period does not drift. When the field cannot be written, the maximum count is clamped into a safe window, and a signed 8-bit random offset is added to it. Each re-arm starts from a base word saved at start, never from the previous randomized word.

Top module: `samp_period_gen`

## Requirements
- R1: While reset is held and in the first cycle after its release, `ctl_word` is zero and `ctl_load` is low.
- R2: The random source starts at 0xF00D. Each step shifts right by one, and bit 15 receives the XOR of bits 0, 2, 3 and 5. It steps exactly once per arm (start or accepted sample), and that arm uses the stepped value.
- R3: A start is followed one clock later by a new `ctl_word` and a one-cycle `ctl_load` pulse. `ctl_load` is never high unless start, stop or sample_vld was high in the previous cycle.
- R4: The base maximum count is `req_period` shifted right by 4, then adjusted by the rule of the selected mode. The maximum-count field occupies bits [15:0].
- R5: With `cur_wr_cap` high at start, the base maximum count is the shifted period plus 128, saturating at 0xFFFF. The 20-bit current-count field, bits [51:32], holds the low 12 bits of the random value, and its upper 8 bits are zero.
- R6: With `cur_wr_cap` low at start, the base maximum count is clamped to 0x0081..0xFF80. Each arm adds random bits [11:4] to it as a signed 8-bit value, and the current-count field stays zero.
- R7: Every armed word has bit 17 (enable) set. Bit 19 (count dispatched ops) equals `disp_mode` as sampled at start. All other bits are zero.
- R8: A `sample_vld` pulse while running re-arms from the base saved at start. Changes to `req_period`, `cur_wr_cap` or `disp_mode` after start have no effect until the next start.
- R9: A stop clears `ctl_word` to zero one clock later, with a `ctl_load` pulse, and ends running. If start and stop arrive in the same cycle, the stop wins and the random source does not step.
- R10: A `sample_vld` pulse while stopped produces no `ctl_load`, leaves `ctl_word` unchanged and does not step the random source. The word issued at the next start shows that the random source did not step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_period | input | 32 | Requested sampling period |
| cur_wr_cap | input | 1 | High when the counter's current-count field is writable |
| disp_mode | input | 1 | Selects counting of dispatched ops |
| start | input | 1 | Start pulse: save the base and issue the first armed word |
| stop | input | 1 | Stop pulse: issue the all-zero word |
| sample_vld | input | 1 | A sample was taken; re-arm if running |
| ctl_word | output | 64 | Control word to be written to the counter |
| ctl_load | output | 1 | One-cycle pulse when a new control word is issued |

## Verification
On every cycle, the assertions check the following:
- a stop is followed by the zero word;
- a load pulse always has a command behind it;
- the word holds still between loads;
- armed words carry the enable bit;
- the current-count field obeys the bounds of the selected mode.

The exact random sequence cannot be checked that way, and neither can the saturation and clamp values or the use of the saved base after inputs change. These are shown by the bench's scenarios. In them, a scoreboard compares every issued word against a model that steps its own copy of the random source. A sample sent while stopped is checked twice: directly at the ports, and through the word issued at the following start.

// File: rtl/spg_pkg.sv
package spg_pkg;
  localparam int CTL_W     = 64;
  localparam int MAX_W     = 16;
  localparam int CUR_LSB   = 32;
  localparam int CUR_W     = 20;
  localparam int EN_BIT    = 17;
  localparam int DISP_BIT  = 19;
  localparam int RAND_BITS = 12;
  localparam int OFF_LSB   = 4;
  localparam int OFF_W     = RAND_BITS - OFF_LSB;
  localparam int COMP      = 1 << (RAND_BITS - 5);
  localparam logic [MAX_W-1:0] MAX_FIELD = '1;
  localparam logic [MAX_W-1:0] CLAMP_LO  = 16'h0081;
  localparam logic [MAX_W-1:0] CLAMP_HI  = 16'hFF80;

  typedef struct packed {
    logic [MAX_W-1:0] max_cnt;
    logic             disp;
  } base_t;

  function automatic logic [CTL_W-1:0] pack_word(input logic [MAX_W-1:0] mx,
                                                 input logic [CUR_W-1:0] cur,
                                                 input logic disp);
    logic [CTL_W-1:0] w;
    w = '0;
    w[MAX_W-1:0] = mx;
    w[EN_BIT] = 1'b1;
    w[DISP_BIT] = disp;
    w[CUR_LSB +: CUR_W] = cur;
    return w;
  endfunction
endpackage

// File: rtl/spg_lfsr.sv
module spg_lfsr #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    SEED = 16'hF00D,
  parameter logic [W-1:0]    TAPS = 16'h002D
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] nxt
);
  logic [W-1:0] q;
  logic         fb;

  assign fb  = ^(q & TAPS);
  assign nxt = {fb, q[W-1:1]};

  always_ff @(posedge clk) begin
    if (rst)      q <= SEED;
    else if (adv) q <= nxt;
  end
endmodule

// File: rtl/spg_base_calc.sv
module spg_base_calc
  import spg_pkg::*;
#(
  parameter int REQ_W = 32
) (
  input  logic [REQ_W-1:0] req_period,
  input  logic             wr_mode,
  output logic [MAX_W-1:0] base_max
);
  localparam int SW = REQ_W + 1;
  logic [REQ_W-1:0] shifted;
  logic [SW-1:0]    sum;

  assign shifted = req_period >> 4;
  assign sum     = {1'b0, shifted} + SW'(COMP);

  always_comb begin
    if (wr_mode) begin
      if (sum > SW'(MAX_FIELD)) base_max = MAX_FIELD;
      else                      base_max = sum[MAX_W-1:0];
    end else begin
      if (shifted < REQ_W'(CLAMP_LO))      base_max = CLAMP_LO;
      else if (shifted > REQ_W'(CLAMP_HI)) base_max = CLAMP_HI;
      else                                 base_max = shifted[MAX_W-1:0];
    end
  end
endmodule

// File: rtl/spg_randomizer.sv
module spg_randomizer
  import spg_pkg::*;
#(
  parameter int LFSR_W = 16
) (
  input  base_t             base,
  input  logic              wr_mode,
  input  logic [LFSR_W-1:0] rnd,
  output logic [CTL_W-1:0]  word
);
  logic [OFF_W-1:0] off;
  logic [MAX_W-1:0] off_ext;
  logic [MAX_W-1:0] mx;
  logic [CUR_W-1:0] cur;

  assign off     = rnd[RAND_BITS-1:OFF_LSB];
  assign off_ext = {{(MAX_W-OFF_W){off[OFF_W-1]}}, off};

  generate
    if (CUR_W > RAND_BITS) begin : g_pad
      assign cur = wr_mode ? {{(CUR_W-RAND_BITS){1'b0}}, rnd[RAND_BITS-1:0]} : '0;
    end else begin : g_nopad
      assign cur = wr_mode ? rnd[CUR_W-1:0] : '0;
    end
  endgenerate

  assign mx   = wr_mode ? base.max_cnt : base.max_cnt + off_ext;
  assign word = pack_word(mx, cur, base.disp);
endmodule

// File: rtl/samp_period_gen.sv
module samp_period_gen
  import spg_pkg::*;
#(
  parameter int                REQ_W  = 32,
  parameter int                LFSR_W = 16,
  parameter logic [LFSR_W-1:0] SEED   = 16'hF00D,
  parameter logic [LFSR_W-1:0] TAPS   = 16'h002D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REQ_W-1:0] req_period,
  input  logic             cur_wr_cap,
  input  logic             disp_mode,
  input  logic             start,
  input  logic             stop,
  input  logic             sample_vld,
  output logic [CTL_W-1:0] ctl_word,
  output logic             ctl_load
);
  logic              running_q;
  logic              wr_mode_q;
  base_t             base_q;
  base_t             base_new;
  base_t             base_sel;
  logic              mode_sel;
  logic              do_start;
  logic              do_rearm;
  logic [LFSR_W-1:0] rnd_nxt;
  logic [MAX_W-1:0]  new_max;
  logic [CTL_W-1:0]  armed_word;

  assign do_start = start && !stop;
  assign do_rearm = sample_vld && running_q && !stop && !start;

  spg_lfsr #(.W(LFSR_W), .SEED(SEED), .TAPS(TAPS)) u_lfsr (
    .clk (clk),
    .rst (rst),
    .adv (do_start || do_rearm),
    .nxt (rnd_nxt)
  );

  spg_base_calc #(.REQ_W(REQ_W)) u_base (
    .req_period (req_period),
    .wr_mode    (cur_wr_cap),
    .base_max   (new_max)
  );

  assign base_new.max_cnt = new_max;
  assign base_new.disp    = disp_mode;
  assign base_sel = do_start ? base_new : base_q;
  assign mode_sel = do_start ? cur_wr_cap : wr_mode_q;

  spg_randomizer #(.LFSR_W(LFSR_W)) u_rand (
    .base    (base_sel),
    .wr_mode (mode_sel),
    .rnd     (rnd_nxt),
    .word    (armed_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      running_q <= 1'b0;
      wr_mode_q <= 1'b0;
      base_q    <= '0;
      ctl_word  <= '0;
      ctl_load  <= 1'b0;
    end else if (stop) begin
      running_q <= 1'b0;
      ctl_word  <= '0;
      ctl_load  <= 1'b1;
    end else if (do_start) begin
      running_q <= 1'b1;
      wr_mode_q <= cur_wr_cap;
      base_q    <= base_new;
      ctl_word  <= armed_word;
      ctl_load  <= 1'b1;
    end else if (do_rearm) begin
      ctl_word  <= armed_word;
      ctl_load  <= 1'b1;
    end else begin
      ctl_load  <= 1'b0;
    end
  end
endmodule

// File: rtl/spg_chk.sv
module spg_chk
  import spg_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             stop,
  input logic             sample_vld,
  input logic             wr_mode,
  input logic [CTL_W-1:0] ctl_word,
  input logic             ctl_load
);
  AST_STOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    stop |=> (ctl_word == '0 && ctl_load)); // R9
  AST_LOAD_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ctl_load |-> $past(start || stop || sample_vld)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ctl_load |-> $stable(ctl_word)); // R10
  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (rst)
    (ctl_load && ctl_word != '0) |-> ctl_word[EN_BIT]); // R7
  AST_CUR_ZERO_NOWR: assert property (@(posedge clk) disable iff (rst)
    (ctl_word[EN_BIT] && !wr_mode) |-> (ctl_word[CUR_LSB +: CUR_W] == '0)); // R6
  AST_CUR_UPPER_WR: assert property (@(posedge clk) disable iff (rst)
    (ctl_word[EN_BIT] && wr_mode) |-> (ctl_word[CUR_LSB+RAND_BITS +: CUR_W-RAND_BITS] == '0)); // R5
endmodule

bind samp_period_gen spg_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .stop       (stop),
  .sample_vld (sample_vld),
  .wr_mode    (wr_mode_q),
  .ctl_word   (ctl_word),
  .ctl_load   (ctl_load)
);

// File: tb/samp_period_gen_tb_top.sv
`timescale 1ns/1ps
module samp_period_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] req_period = '0;
  logic        cur_wr_cap = 1'b0;
  logic        disp_mode = 1'b0;
  logic        start = 1'b0;
  logic        stop = 1'b0;
  logic        sample_vld = 1'b0;
  logic [63:0] ctl_word;
  logic        ctl_load;

  always #2.5 clk = ~clk;

  samp_period_gen dut_i (
    .clk(clk), .rst(rst), .req_period(req_period), .cur_wr_cap(cur_wr_cap),
    .disp_mode(disp_mode), .start(start), .stop(stop), .sample_vld(sample_vld),
    .ctl_word(ctl_word), .ctl_load(ctl_load)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] m_lfsr = 16'hF00D;
  bit          m_run = 0;
  longint unsigned m_req = 0;
  bit          m_wr = 0;
  bit          m_disp = 0;

  function automatic logic [15:0] step(input logic [15:0] v);
    logic b;
    b = v[0] ^ v[2] ^ v[3] ^ v[5];
    return {b, v[15:1]};
  endfunction

  function automatic logic [63:0] model_word(input longint unsigned req, input bit wr,
                                             input bit disp, input logic [15:0] r);
    longint m;
    longint cur;
    int off;
    m = longint'(req >> 4);
    cur = 0;
    if (wr) begin
      m = m + 128;
      if (m > 65535) m = 65535;
      cur = longint'(r & 16'h0FFF);
    end else begin
      if (m < 129) m = 129;
      if (m > 65408) m = 65408;
      off = int'((r >> 4) & 16'h00FF);
      if (off > 127) off = off - 256;
      m = m + off;
    end
    return 64'(m) | (64'd1 << 17) | (64'(disp) << 19) | (64'(cur) << 32);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [63:0] w, input string tag);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  task automatic do_start(input longint unsigned req, input bit wr, input bit disp, input string tag);
    @(negedge clk);
    req_period = 32'(req); cur_wr_cap = wr; disp_mode = disp; start = 1'b1;
    m_req = req; m_wr = wr; m_disp = disp; m_run = 1;
    m_lfsr = step(m_lfsr);
    push(model_word(m_req, m_wr, m_disp, m_lfsr), tag);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_sample(input string tag);
    @(negedge clk);
    sample_vld = 1'b1;
    if (m_run) begin
      m_lfsr = step(m_lfsr);
      push(model_word(m_req, m_wr, m_disp, m_lfsr), tag);
    end
    @(negedge clk);
    sample_vld = 1'b0;
  endtask

  task automatic do_stop(input bit with_start, input string tag);
    @(negedge clk);
    stop = 1'b1;
    start = with_start;
    m_run = 0;
    push(64'd0, tag);
    @(negedge clk);
    stop = 1'b0;
    start = 1'b0;
  endtask

  // monitor: pop expected items as the design issues words
  always @(negedge clk) begin
    if (!rst && ctl_load) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected load", ctl_word, 64'd0);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(ctl_word === e, t, ctl_word, e);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ctl_word === 64'd0 && ctl_load === 1'b0, "R1 in reset", ctl_word, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(ctl_word === 64'd0 && ctl_load === 1'b0, "R1 after reset", ctl_word, 64'd0);

    do_start(250000, 1, 0, "R5 R4 R2 R3 writable start");
    do_sample("R2 rearm 1");
    do_sample("R2 rearm 2");
    do_sample("R8 rearm 3");
    @(negedge clk);
    req_period = 32'h100; cur_wr_cap = 1'b0; disp_mode = 1'b1;
    do_sample("R8 rearm uses saved base");
    do_stop(0, "R9 stop zero");

    do_sample("R10 sample while stopped");
    check(ctl_load === 1'b0 && ctl_word === 64'd0, "R10 no load while stopped", ctl_word, 64'd0);

    do_start(32'h100, 0, 1, "R6 R7 clamp low with disp");
    do_sample("R6 rearm nonwritable");
    do_sample("R6 rearm nonwritable 2");
    do_start(32'hFFFF_FFF0, 0, 0, "R6 clamp high");
    do_sample("R6 rearm clamp high");
    do_start(32'h000F_FFF0, 1, 0, "R5 saturate");
    do_sample("R5 rearm saturate");
    do_stop(1, "R9 stop wins over start");
    do_sample("R10 ignored sample 2");
    do_start(32'h800, 1, 1, "R10 R2 lfsr not advanced");
    do_sample("R7 disp rearm");
    do_stop(0, "R9 final stop");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3 all expected loads seen", 64'(exp_q.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule